// File: doc/BRIEF.md
# Alarm Match and Watchdog Supervisor

This block sits beside a time-of-day register file and turns its contents into two open-drain-style, active-low outputs: an interrupt line and a reset line. Five alarm bytes are compared against the current month, date, hour, minute and second whenever the one-second tick arrives. A full match raises the alarm flag and pulls the interrupt line low.

A watchdog counter runs on a fast prescaled tick of 16 Hz. Software or an external supervisor keeps it from expiring by toggling the watchdog input pin or by rewriting the watchdog byte. The watchdog byte also picks what an expiry does: it either pulls the shared interrupt line or issues a reset pulse of fixed length. Both event flags sit in one status byte, and a read of that byte clears them.

Registers are written through a simple strobe, address and data port. The alarm bytes sit at 2h (second), 3h (minute), 4h (hour), 5h (date) and 6h (month). The watchdog byte sits at 7h and the status byte at 0h.

Top module: `alarm_wdog_sup`

## Requirements
- R1: After reset, irq_n and rst_out_n are 1 (released), flags is 8'h00, every alarm byte is 0 and the watchdog byte is 0, so the watchdog is disabled.
- R2: On a cycle with sec_tick high, if every alarm field matches, flags bit 6 (alarm) becomes 1 at the next clock edge and irq_n goes low with it. A field matches when its bits 6:0 equal the current value or its bit 7 is set. Without sec_tick, no alarm is raised.
- R3: If any alarm byte with bit 7 clear differs from its current field on the sec_tick cycle, flags bit 6 stays 0.
- R4: Bit 7 of an alarm byte (repeat) makes that field match any current value.
- R5: A cycle with rd_en high and rd_addr = 0h clears flags bits 7 and 6 at the next edge, which releases irq_n. An event that sets a flag in the same cycle wins over the clear.
- R6: The watchdog byte at 7h holds a multiplier M in bits 6:2 and a resolution R in bits 1:0, with R = 0/1/2/3 meaning 1/16 s, 1/4 s, 1 s and 4 s. With M nonzero, the M·4^R-th sub_tick after the last reload is an expiry, which sets flags bit 7 (watchdog) at that edge and restarts the count.
- R7: Bit 7 of the watchdog byte steers an expiry. With bit 7 = 1, irq_n is held low while flags bit 7 is set. With bit 7 = 0, rst_out_n goes low for RST_CYC clocks starting at the expiry edge, and irq_n is not pulled.
- R8: Either edge of wdi reloads the counter. wdi passes through a two-flop synchronizer, so the reload takes effect on the third clock edge after the change. A write to 7h also reloads the counter, using the new value.
- R9: With M = 0 the watchdog never expires, whatever the resolution and the sub_tick count.
- R10: Writes to addresses 0h, 1h and 8h to Fh leave the alarm and watchdog settings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse each second; cur_* hold the new time on that cycle |
| sub_tick | input | 1 | One-cycle pulse every 1/16 s |
| cur_sec | input | FIELD_W | Current seconds |
| cur_min | input | FIELD_W | Current minutes |
| cur_hour | input | FIELD_W | Current hours |
| cur_date | input | FIELD_W | Current day of month |
| cur_mon | input | FIELD_W | Current month |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe (a read of 0h clears flags) |
| rd_addr | input | 4 | Read address |
| wdi | input | 1 | Watchdog kick pin, asynchronous |
| irq_n | output | 1 | Interrupt, active low (0 pulls the line) |
| rst_out_n | output | 1 | Reset, active low (0 pulls the line) |
| flags | output | 8 | Status byte: bit 7 watchdog, bit 6 alarm, others 0 |

## Verification
If the alarm byte storage or the comparator goes wrong, the fault shows at flags bit 6 and irq_n on the clock edge that follows the very next sec_tick. That next tick is also where the bench looks. If the watchdog counter is loaded or decremented wrongly, the expiry lands on the wrong sub_tick. The bench therefore checks the flag one tick before and exactly at the expected expiry, and it times the reset pulse one clock at a time. A steering fault shows at once as the wrong one of irq_n and rst_out_n.

// File: rtl/alarm_wdog_sup.sv
module alarm_wdog_sup #(
  parameter int FIELD_W = 7,
  parameter int RST_CYC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic               sub_tick,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_hour,
  input  logic [FIELD_W-1:0] cur_date,
  input  logic [FIELD_W-1:0] cur_mon,
  input  logic               wr_en,
  input  logic [3:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               rd_en,
  input  logic [3:0]         rd_addr,
  input  logic               wdi,
  output logic               irq_n,
  output logic               rst_out_n,
  output logic [7:0]         flags
);
  localparam int NFLD  = 5;
  localparam int CNT_W = 11;
  localparam int RCW   = $clog2(RST_CYC + 1);

  logic [FIELD_W:0]   alm_q [NFLD];
  logic [FIELD_W-1:0] cur_f [NFLD];
  logic [NFLD-1:0]    fld_ok;
  logic [7:0]         wd_q;
  logic [CNT_W-1:0]   wd_cnt;
  logic [RCW-1:0]     rst_cnt;
  logic [2:0]         wdi_s;
  logic               alm_f, wd_f;

  function automatic logic [CNT_W-1:0] ld_of(input logic [7:0] b);
    return CNT_W'(b[6:2]) << {b[1:0], 1'b0};
  endfunction

  assign cur_f[0] = cur_sec;
  assign cur_f[1] = cur_min;
  assign cur_f[2] = cur_hour;
  assign cur_f[3] = cur_date;
  assign cur_f[4] = cur_mon;

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        alm_q[i] <= '0;
      else if (wr_en && wr_addr == 4'(i + 2))
        alm_q[i] <= {wr_data[7], wr_data[FIELD_W-1:0]};
    assign fld_ok[i] = alm_q[i][FIELD_W] | (alm_q[i][FIELD_W-1:0] == cur_f[i]);
  end

  wire wd_wr     = wr_en && wr_addr == 4'h7;
  wire wdi_edge  = wdi_s[2] ^ wdi_s[1];
  wire reload    = wd_wr || wdi_edge;
  wire wd_exp    = sub_tick && !reload && wd_cnt == CNT_W'(1);
  wire alm_hit   = sec_tick && (&fld_ok);
  wire clr       = rd_en && rd_addr == 4'h0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wd_q    <= '0;
      wd_cnt  <= '0;
      wdi_s   <= '0;
      rst_cnt <= '0;
      alm_f   <= 1'b0;
      wd_f    <= 1'b0;
    end else begin
      wdi_s <= {wdi_s[1:0], wdi};
      if (wd_wr) wd_q <= wr_data;
      if (reload)
        wd_cnt <= ld_of(wd_wr ? wr_data : wd_q);
      else if (wd_exp)
        wd_cnt <= ld_of(wd_q);
      else if (sub_tick && wd_cnt != '0)
        wd_cnt <= wd_cnt - 1'b1;
      if (wd_exp && !wd_q[7])
        rst_cnt <= RCW'(RST_CYC);
      else if (rst_cnt != '0)
        rst_cnt <= rst_cnt - 1'b1;
      alm_f <= alm_hit | (alm_f & ~clr);
      wd_f  <= wd_exp  | (wd_f  & ~clr);
    end

  assign irq_n     = ~(alm_f | (wd_f & wd_q[7]));
  assign rst_out_n = (rst_cnt == '0);
  assign flags     = {wd_f, alm_f, 6'b0};
endmodule

module alarm_wdog_sup_chk #(
  parameter int RST_CYC = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sec_tick,
  input logic        sub_tick,
  input logic        wr_en,
  input logic [3:0]  wr_addr,
  input logic        rd_en,
  input logic [3:0]  rd_addr,
  input logic        irq_n,
  input logic        rst_out_n,
  input logic [7:0]  flags,
  input logic [7:0]  wd_q,
  input logic [10:0] wd_cnt
);
  localparam int LW = $clog2(RST_CYC + 2) + 1;
  logic [LW-1:0] lowrun;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lowrun <= '0;
    else if (rst_out_n || sub_tick) lowrun <= '0;
    else lowrun <= lowrun + 1'b1;

  p_irq_has_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flags[6] || flags[7]));
  p_alarm_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[6]) |-> $past(sec_tick));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 4'h0 && !sec_tick && !sub_tick) |=> flags[7:6] == 2'b00);
  p_wd_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[7]) |-> $past(sub_tick));
  p_irq_steer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[7] && wd_q[7]) |-> !irq_n);
  p_rst_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> ($past(sub_tick) && !$past(wd_q[7])));
  p_rst_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lowrun <= LW'(RST_CYC));
  p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_q[6:2] == 5'd0 && !(wr_en && wr_addr == 4'h7)) |=> wd_cnt == 11'd0);
endmodule

bind alarm_wdog_sup alarm_wdog_sup_chk #(.RST_CYC(RST_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .sub_tick(sub_tick),
  .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
  .irq_n(irq_n), .rst_out_n(rst_out_n), .flags(flags),
  .wd_q(wd_q), .wd_cnt(wd_cnt)
);

// File: tb/alarm_wdog_sup_tb_top.sv
`timescale 1ns/1ps
module alarm_wdog_sup_tb_top;
  localparam int FW = 7;
  localparam int RC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 0, sub_tick = 0, wr_en = 0, rd_en = 0, wdi = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [FW-1:0] cur [5];
  logic irq_n, rst_out_n;
  logic [7:0] flags;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alarm_wdog_sup #(.FIELD_W(FW), .RST_CYC(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .sub_tick(sub_tick),
    .cur_sec(cur[0]), .cur_min(cur[1]), .cur_hour(cur[2]),
    .cur_date(cur[3]), .cur_mon(cur[4]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .wdi(wdi),
    .irq_n(irq_n), .rst_out_n(rst_out_n), .flags(flags));

  function automatic bit exp_match(input logic [7:0] a [5], input logic [FW-1:0] c [5]);
    for (int i = 0; i < 5; i++)
      if (!a[i][7] && a[i][FW-1:0] != c[i]) return 0;
    return 1;
  endfunction

  function automatic int wd_ticks(input logic [7:0] b);
    return int'(b[6:2]) * (1 << (2 * int'(b[1:0])));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_clear();
    @(negedge clk); rd_en = 1; rd_addr = 4'h0;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic sec_pulse();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  task automatic sub_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sub_tick = 1;
      @(negedge clk); sub_tick = 0;
    end
  endtask

  task automatic kick();
    @(negedge clk); wdi = ~wdi;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_alarm(input logic [7:0] a [5]);
    for (int i = 0; i < 5; i++) wr(4'(i + 2), a[i]);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R1..): actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] a [5];
    int n, len, pre;
    logic [7:0] wb;
    bit m;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 5; i++) cur[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq_n", irq_n, 1);
    chk("R1 rst_out_n", rst_out_n, 1);
    chk("R1 flags", flags, 0);
    sub_pulses(70);
    chk("R1 R9 wd off after reset", flags[7], 0);

    a = '{8'd5, 8'd6, 8'd7, 8'd8, 8'd9};
    set_alarm(a);
    for (int i = 0; i < 5; i++) cur[i] = FW'(5 + i);
    repeat (4) @(negedge clk);
    chk("R2 no flag without sec_tick", flags[6], 0);
    sec_pulse();
    chk("R2 alarm flag", flags[6], 1);
    chk("R2 irq_n low", irq_n, 0);
    rd_clear();
    chk("R5 flag cleared", flags[6], 0);
    chk("R5 irq released", irq_n, 1);
    cur[4] = FW'(10);
    sec_pulse();
    chk("R3 month mismatch", flags[6], 0);
    wr(4'h6, 8'h80);
    sec_pulse();
    chk("R4 month repeat", flags[6], 1);
    @(negedge clk); sec_tick = 1; rd_en = 1; rd_addr = 4'h0;
    @(negedge clk); sec_tick = 0; rd_en = 0;
    chk("R5 set wins over clear", flags[6], 1);
    rd_clear();
    for (int ad = 0; ad < 16; ad++)
      if (ad < 2 || ad > 7) wr(4'(ad), 8'h80);
    cur[0] = FW'(6);
    sec_pulse();
    chk("R10 sec alarm kept", flags[6], 0);

    for (int it = 0; it < 40; it++) begin
      for (int i = 0; i < 5; i++) begin
        a[i] = {($urandom % 4 == 0) ? 1'b1 : 1'b0, 7'($urandom % 3)};
        cur[i] = FW'($urandom % 3);
      end
      set_alarm(a);
      rd_clear();
      sec_pulse();
      m = exp_match(a, cur);
      chk(m ? "R2 random match" : "R3 random mismatch", flags[6], int'(m));
      chk("R2 random irq", irq_n, int'(!m));
    end
    rd_clear();

    wr(4'h7, {1'b0, 5'd0, 2'd3});
    sub_pulses(100);
    chk("R9 M=0 no expiry", flags[7], 0);
    chk("R9 M=0 no reset", rst_out_n, 1);

    wr(4'h7, {1'b1, 5'd3, 2'd0});
    sub_pulses(2);
    kick();
    sub_pulses(2);
    chk("R8 wdi kick reloads", flags[7], 0);
    sub_pulses(1);
    chk("R8 expiry after kick", flags[7], 1);
    rd_clear();
    sub_pulses(2);
    wr(4'h7, {1'b1, 5'd3, 2'd0});
    sub_pulses(2);
    chk("R8 write reloads", flags[7], 0);
    sub_pulses(1);
    chk("R8 expiry after write", flags[7], 1);
    rd_clear();

    wr(4'h7, {1'b0, 5'd1, 2'd3});
    sub_pulses(63);
    chk("R6 4s res before", flags[7], 0);
    sub_pulses(1);
    chk("R6 4s res expiry", flags[7], 1);
    len = 0;
    while (!rst_out_n && len < 100) begin len++; @(negedge clk); end
    chk("R7 reset pulse length", len, RC);
    chk("R7 reset steer irq high", irq_n, 1);
    rd_clear();

    for (int it = 0; it < 24; it++) begin
      wb = {1'($urandom % 2), 5'(1 + $urandom % 6), 2'($urandom % 2)};
      n = wd_ticks(wb);
      wr(4'h7, wb);
      rd_clear();
      pre = int'($urandom % n);
      sub_pulses(pre);
      kick();
      sub_pulses(n - 1);
      chk("R6 random before expiry", flags[7], 0);
      sub_pulses(1);
      chk("R6 random expiry", flags[7], 1);
      if (wb[7]) begin
        chk("R7 random irq steer", irq_n, 0);
        chk("R7 random irq no reset", rst_out_n, 1);
        rd_clear();
        chk("R5 wd clear releases irq", irq_n, 1);
      end else begin
        chk("R7 random reset steer irq", irq_n, 1);
        len = 0;
        while (!rst_out_n && len < 100) begin len++; @(negedge clk); end
        chk("R7 random pulse length", len, RC);
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule